// File: doc/BRIEF.md
# Packed Fixed-Point Multiply Unit

This block is a pipelined SIMD multiplier for 128-bit operands split into eight 16-bit lanes. It has two operations, chosen per operation by a single mode input. In pair mode each lane multiplies two unsigned bytes from operand A by two signed bytes from operand B. The two products are added and the sum is clamped to the signed 16-bit range. In rounding mode each lane forms the signed 16x16 product and keeps a rounded, scaled high half. This is the usual Q15 fractional multiply, and it wraps rather than saturates.

The unit accepts one operation per clock with no back-pressure. Each accepted operation comes back exactly two clocks later on the output with a valid strobe. The first register stage holds the raw products and the second holds the reduced lane results. Between results the output keeps its last value.

Top module: `packed_fxp_mul`

## Requirements
- R1: `out_valid` is high exactly two clock edges after each edge at which `in_valid` was sampled high, and low otherwise.
- R2: With `in_mode` = 0 (pair mode), lane i (bits 16i+15..16i) of the result equals A[byte 2i]·B[byte 2i] + A[byte 2i+1]·B[byte 2i+1]. Byte k occupies bits 8k+7..8k, A bytes are read as unsigned 0..255 and B bytes as signed −128..127.
- R3: In pair mode, a lane sum above 32767 is clamped to 0x7FFF (for example A bytes 0xFF with B bytes 0x7F).
- R4: In pair mode, a lane sum below −32768 is clamped to 0x8000 (for example A bytes 0xFF with B bytes 0x80).
- R5: With `in_mode` = 1 (rounding mode), lane i is formed from the signed 32-bit product P of the two signed 16-bit lanes. T = P[31:14], an 18-bit value, and the lane result is bits [16:1] of T+1, taken modulo 2^18.
- R6: In rounding mode no clamping is applied: 0x8000 × 0x8000 gives 0x8000.
- R7: Operations may arrive on consecutive cycles with different modes, and each produces the result of its own mode and operands, in arrival order.
- R8: While `out_valid` is low, `out_data` keeps its previous value.
- R9: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero and discards operations still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present on the inputs |
| in_mode | input | 1 | 0 = byte pair multiply-add with clamp, 1 = rounded high multiply |
| in_a | input | 128 | Operand A (unsigned bytes in pair mode, signed lanes in rounding mode) |
| in_b | input | 128 | Operand B (signed bytes or signed lanes) |
| out_valid | output | 1 | Result present on `out_data` |
| out_data | output | 128 | Eight 16-bit lane results |

## Verification
The two functions that can share a cycle are a pair-mode reduction in the second stage and a rounding-mode product forming in the first stage, because the mode travels with each operation through the pipeline. The bench provokes this by issuing back-to-back operations that alternate and randomise the mode, with clamp and wrap corner operands placed right next to ordinary ones. A scoreboard compares every result against a model computed from the requirements, and it also compares the cycle of arrival, so a mode or operand taken from the neighbouring operation shows up as a lane mismatch.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  typedef enum logic {
    MODE_PAIR  = 1'b0,
    MODE_ROUND = 1'b1
  } pfm_mode_e;

  localparam int PFM_LANES_DEF  = 8;
  localparam int PFM_LANE_W_DEF = 16;

endpackage

// File: rtl/pfm_mul_lane.sv
// Stage 1 of one lane: forms the raw products for the selected mode.
module pfm_mul_lane
  import pfm_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  pfm_mode_e                 mode_i,
  input  logic [LANE_W-1:0]         a_i,
  input  logic [LANE_W-1:0]         b_i,
  output logic signed [LANE_W+1:0]  plo_o,
  output logic signed [LANE_W+1:0]  phi_o,
  output logic signed [2*LANE_W-1:0] pw_o
);
  localparam int BYTE_W = LANE_W / 2;
  localparam int PB     = 2 * BYTE_W + 2;
  localparam int PW     = 2 * LANE_W;

  logic signed [BYTE_W:0] ua_lo, ua_hi, sb_lo, sb_hi;
  logic signed [PB-1:0]   blo, bhi;
  logic signed [PW-1:0]   bw;

  always_comb begin
    // zero-extend A bytes, sign-extend B bytes
    ua_lo = signed'({1'b0, a_i[BYTE_W-1:0]});
    ua_hi = signed'({1'b0, a_i[LANE_W-1:BYTE_W]});
    sb_lo = signed'({b_i[BYTE_W-1], b_i[BYTE_W-1:0]});
    sb_hi = signed'({b_i[LANE_W-1], b_i[LANE_W-1:BYTE_W]});
    blo   = PB'(ua_lo) * PB'(sb_lo);
    bhi   = PB'(ua_hi) * PB'(sb_hi);
    bw    = PW'(signed'(a_i)) * PW'(signed'(b_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      plo_o <= '0;
      phi_o <= '0;
      pw_o  <= '0;
    end else if (load) begin
      // only the product set of the active mode toggles
      if (mode_i == MODE_PAIR) begin
        plo_o <= blo;
        phi_o <= bhi;
      end else begin
        pw_o  <= bw;
      end
    end
  end

endmodule

// File: rtl/pfm_fin_lane.sv
// Stage 2 of one lane: clamped pair sum or rounded high half.
module pfm_fin_lane
  import pfm_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  pfm_mode_e                  mode_i,
  input  logic signed [LANE_W+1:0]   plo_i,
  input  logic signed [LANE_W+1:0]   phi_i,
  input  logic signed [2*LANE_W-1:0] pw_i,
  output logic [LANE_W-1:0]          res_o
);
  localparam int PB   = LANE_W + 2;
  localparam int SW   = PB + 1;
  localparam int PW   = 2 * LANE_W;
  localparam int KEEP = LANE_W + 2;
  localparam logic signed [SW-1:0] SAT_HI = SW'((1 << (LANE_W - 1)) - 1);
  localparam logic signed [SW-1:0] SAT_LO = ~SAT_HI;

  logic signed [SW-1:0] pair_sum;
  logic [LANE_W-1:0]    pair_res;
  logic [KEEP-1:0]      kept;
  logic [KEEP-1:0]      bumped;
  logic [LANE_W-1:0]    rnd_res;
  logic                 unused_bits;

  always_comb begin
    pair_sum = SW'(plo_i) + SW'(phi_i);
    if (pair_sum > SAT_HI)      pair_res = SAT_HI[LANE_W-1:0];
    else if (pair_sum < SAT_LO) pair_res = SAT_LO[LANE_W-1:0];
    else                        pair_res = pair_sum[LANE_W-1:0];

    kept    = pw_i[PW-1 -: KEEP];
    bumped  = kept + KEEP'(1);
    rnd_res = bumped[LANE_W:1];
  end

  assign unused_bits = ^{pw_i[PW-KEEP-1:0], bumped[KEEP-1], bumped[0],
                         pair_sum[SW-1:LANE_W]};

  always_ff @(posedge clk) begin
    if (rst)       res_o <= '0;
    else if (load) res_o <= (mode_i == MODE_PAIR) ? pair_res : rnd_res;
  end

endmodule

// File: rtl/packed_fxp_mul.sv
module packed_fxp_mul
  import pfm_pkg::*;
#(
  parameter int LANES  = PFM_LANES_DEF,
  parameter int LANE_W = PFM_LANE_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      in_mode,
  input  logic [LANES*LANE_W-1:0]   in_a,
  input  logic [LANES*LANE_W-1:0]   in_b,
  output logic                      out_valid,
  output logic [LANES*LANE_W-1:0]   out_data
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int PB     = LANE_W + 2;
  localparam int PW     = 2 * LANE_W;

  pfm_mode_e mode_in;
  logic      s1_valid;
  pfm_mode_e s1_mode;

  assign mode_in = pfm_mode_e'(in_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_mode   <= MODE_PAIR;
      out_valid <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      if (in_valid) s1_mode <= mode_in;
      out_valid <= s1_valid;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [PB-1:0] plo, phi;
    logic signed [PW-1:0] pw;

    pfm_mul_lane #(.LANE_W(LANE_W)) u_mul (
      .clk    (clk),
      .rst    (rst),
      .load   (in_valid),
      .mode_i (mode_in),
      .a_i    (in_a[g*LANE_W +: LANE_W]),
      .b_i    (in_b[g*LANE_W +: LANE_W]),
      .plo_o  (plo),
      .phi_o  (phi),
      .pw_o   (pw)
    );

    pfm_fin_lane #(.LANE_W(LANE_W)) u_fin (
      .clk    (clk),
      .rst    (rst),
      .load   (s1_valid),
      .mode_i (s1_mode),
      .plo_i  (plo),
      .phi_i  (phi),
      .pw_i   (pw),
      .res_o  (out_data[g*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/packed_fxp_mul_chk.sv
module packed_fxp_mul_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_mode,
  input logic [15:0]       a_lo,
  input logic [15:0]       b_lo,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  // R1: two-cycle latency, both directions
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);

  // R8: output held between results
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_data));

  // R3: upper clamp in lane 0
  p_sat_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_valid && !in_mode && a_lo == 16'hFFFF &&
                        b_lo == 16'h7F7F, 2)) |-> out_data[15:0] == 16'h7FFF);

  // R4: lower clamp in lane 0
  p_sat_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_valid && !in_mode && a_lo == 16'hFFFF &&
                        b_lo == 16'h8080, 2)) |-> out_data[15:0] == 16'h8000);

  // R6: most negative squared wraps to 0x8000
  p_round_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_valid && in_mode && a_lo == 16'h8000 &&
                        b_lo == 16'h8000, 2)) |-> out_data[15:0] == 16'h8000);

endmodule

bind packed_fxp_mul packed_fxp_mul_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_mode   (in_mode),
  .a_lo      (in_a[15:0]),
  .b_lo      (in_b[15:0]),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/packed_fxp_mul_bench.sv
`timescale 1ns/1ps
module packed_fxp_mul_bench;
  localparam int LANES = 8;
  localparam int LW    = 16;
  localparam int DW    = LANES * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_mode = 1'b0;
  logic [DW-1:0] in_a = '0;
  logic [DW-1:0] in_b = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  packed_fxp_mul u_packed_fxp_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];
  int            when_q[$];
  string         tag_q[$];
  logic [DW-1:0] last_exp = '0;
  logic [31:0]   rng = 32'h1234_5678;

  function automatic logic [DW-1:0] model(logic m, logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!m) begin
        int s;
        s = int'(a[16*i +: 8]) * int'($signed(b[16*i +: 8]))
          + int'(a[16*i+8 +: 8]) * int'($signed(b[16*i+8 +: 8]));
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        r[16*i +: 16] = 16'(s);
      end else begin
        longint p, t;
        p = longint'($signed(a[16*i +: 16])) * longint'($signed(b[16*i +: 16]));
        t = (p >>> 14) + 1;
        r[16*i +: 16] = t[16:1];
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send(logic m, logic [DW-1:0] a, logic [DW-1:0] b,
                      logic [DW-1:0] exp, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_a = a; in_b = b;
    exp_q.push_back(exp);
    when_q.push_back(cyc + 2);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected out_valid", DW'(1), DW'(0));
      end else begin
        logic [DW-1:0] e;
        int w;
        string t;
        e = exp_q.pop_front();
        w = when_q.pop_front();
        t = tag_q.pop_front();
        check(t, out_data, e);
        check("R1 latency", DW'(cyc), DW'(w));
        last_exp = e;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] ra, rb;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 out_valid in reset", DW'(out_valid), DW'(0));
    check("R9 out_data in reset", out_data, '0);
    rst = 1'b0;

    // R2: pair mode, ordinary and unsigned-A patterns
    send(0, '0, '0, '0, "R2 zeros");
    send(0, {8{16'h0080}}, {8{16'h0001}}, {8{16'h0080}}, "R2 unsigned A byte");
    send(0, {8{16'hC803}}, {8{16'hFE05}}, model(0, {8{16'hC803}}, {8{16'hFE05}}), "R2 mixed signs");
    send(0, 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10,
            128'hFFEE_DDCC_7F80_0102_F00F_55AA_1234_8001,
            model(0, 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10,
                     128'hFFEE_DDCC_7F80_0102_F00F_55AA_1234_8001), "R2 per-lane bytes");
    // R3 / R4 clamps and the exact boundary
    send(0, {8{16'hFFFF}}, {8{16'h7F7F}}, {8{16'h7FFF}}, "R3 clamp high");
    send(0, {8{16'hBFFF}}, {8{16'h027F}}, {8{16'h7FFF}}, "R3 exact 32767 not clamped");
    send(0, {8{16'hFFFF}}, {8{16'h8080}}, {8{16'h8000}}, "R4 clamp low");
    send(0, {8{16'h80FF}}, {8{16'h0080}}, model(0, {8{16'h80FF}}, {8{16'h0080}}), "R4 near low bound");
    // R5 / R6 rounding mode
    send(1, {8{16'h7FFF}}, {8{16'h7FFF}}, {8{16'h7FFE}}, "R5 max squared");
    send(1, {8{16'h4000}}, {8{16'h4000}}, {8{16'h2000}}, "R5 half squared");
    send(1, {8{16'h8000}}, {8{16'h7FFF}}, {8{16'h8001}}, "R5 min times max");
    send(1, {8{16'hFFFF}}, {8{16'h0001}}, {8{16'h0000}}, "R5 minus one times one");
    send(1, {8{16'h8000}}, {8{16'h8000}}, {8{16'h8000}}, "R6 wrap not clamped");
    idle(1);
    idle(3);

    // R8: hold while idle
    check("R8 held data", out_data, last_exp);
    check("R8 valid low while idle", DW'(out_valid), DW'(0));

    // R7: back-to-back alternating and random modes
    for (int k = 0; k < 40; k++) begin
      logic m;
      rng = nxt(rng); ra[31:0] = rng; rng = nxt(rng); ra[63:32] = rng;
      rng = nxt(rng); ra[95:64] = rng; rng = nxt(rng); ra[127:96] = rng;
      rng = nxt(rng); rb[31:0] = rng; rng = nxt(rng); rb[63:32] = rng;
      rng = nxt(rng); rb[95:64] = rng; rng = nxt(rng); rb[127:96] = rng;
      if (k % 8 == 3) ra[15:0] = 16'hFFFF;
      if (k % 8 == 3) rb[15:0] = 16'h7F7F;
      if (k % 8 == 6) begin ra[15:0] = 16'h8000; rb[15:0] = 16'h8000; end
      rng = nxt(rng);
      m = (k < 10) ? k[0] : rng[3];
      if (k % 8 == 3) m = 1'b0;
      if (k % 8 == 6) m = 1'b1;
      send(m, ra, rb, model(m, ra, rb), "R7 back-to-back mixed");
    end
    idle(4);

    // R9: reset discards an operation in flight
    send(1, {8{16'h7FFF}}, {8{16'h7FFF}}, {8{16'h7FFE}}, "R9 flushed");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    exp_q.delete(); when_q.delete(); tag_q.delete();
    repeat (2) @(negedge clk);
    check("R9 valid cleared", DW'(out_valid), DW'(0));
    check("R9 data cleared", out_data, '0);
    rst = 1'b0;
    idle(4);
    check("R9 nothing emerges after reset", DW'(out_valid), DW'(0));

    check("R1 queue drained", DW'(exp_q.size()), DW'(0));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule